// File: doc/BRIEF.md
# Load Forwarding and Pipeline Hazard Unit

This purely combinational block sits beside the decode stage of a five-stage in-order pipeline whose only forwarding producer is a memory load. For each of the two decode source registers it looks for a pending load write to the same register. That write can be in the memory stage, where the value has just been read, or in the writeback bank, where the value waits to be committed. The block then delivers the operand from the youngest matching producer. If nothing matches it passes the register-file read through. A source equal to the "no register" code yields zero.

The block also detects the load-use case. In that case a load still in execute targets a register that decode names. Forwarding cannot cover this, because the loaded value does not yet exist. When it happens, the block holds the fetch and decode banks and injects a nop into the execute bank. The dependent instruction then re-evaluates in decode one cycle later and picks the value up from the memory stage. Detection is deliberately coarse: any decode source that matches counts, whether or not the instruction will read it.

The operand-select path is built once per source port through a generate loop. Both ports therefore follow identical rules. A shared package holds the select encoding and the control bundle.

Top module: `fhu_fwd_hazard`

## Requirements
- R1: When a decode source equals the "no register" code (4'hF by default), its operand output is 0 regardless of every other input, and that source never matches any later-stage destination.
- R2: When a decode source matches the memory-stage load destination, the operand output is the memory-stage load data.
- R3: When a decode source matches the writeback load destination but not the memory-stage destination, the operand output is the writeback load data.
- R4: When both the memory-stage and writeback destinations match a source, the memory-stage data is selected.
- R5: When no later-stage destination matches a valid source, the operand output is that port's register-file read value.
- R6: Sources A and B are resolved independently by the same rules, so each may take a different producer in the same cycle.
- R7: When the execute-stage icode equals the load code (4'h5 by default) and its destination equals source A, `hold_fetch`, `hold_decode` and `flush_execute` are all 1.
- R8: The hazard of R7 is also raised when the execute load destination equals source B. This holds even when source A does not match.
- R9: When the execute-stage icode is not the load code, no control output is raised, even if its destination matches a decode source.
- R10: `hold_fetch`, `hold_decode` and `flush_execute` always carry the same value, and all three are 0 when no hazard exists.
- R11: A hazard does not alter operand selection; the operands still follow R1 to R5.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| dec_src_a | input | REG_W | Decode source register A |
| dec_src_b | input | REG_W | Decode source register B |
| ex_icode | input | ICODE_W | Instruction code currently in execute |
| ex_load_dst | input | REG_W | Load destination of the execute-stage instruction |
| mem_load_dst | input | REG_W | Load destination in the memory stage (none code if not a load) |
| mem_load_data | input | DATA_W | Value read by the memory stage |
| wb_load_dst | input | REG_W | Load destination held in the writeback bank |
| wb_load_data | input | DATA_W | Loaded value held in the writeback bank |
| rf_rd_a | input | DATA_W | Register-file read for source A |
| rf_rd_b | input | DATA_W | Register-file read for source B |
| opnd_a | output | DATA_W | Resolved operand A |
| opnd_b | output | DATA_W | Resolved operand B |
| hold_fetch | output | 1 | Hold the fetch bank |
| hold_decode | output | 1 | Hold the decode bank |
| flush_execute | output | 1 | Load a nop into the execute bank |

## Verification
The hardest situation to create is the one where the load-use hazard and forwarding happen in the same cycle. A load sits in execute while an older load to the same register sits in the memory stage. The controls must rise while the operand is still taken from the memory stage. The stimulus sets the execute and memory destinations to one register and names that register as source A. A second case drives the hazard through source B alone, and a sweep of every source code against a fixed execute load shows that exactly one code triggers it. That sweep also shows that the none code neither triggers the hazard nor forwards.

// File: rtl/fhu_pkg.sv
package fhu_pkg;

    // Producer chosen for one decode operand, in priority order.
    typedef enum logic [1:0] {
        SEL_ZERO = 2'd0,
        SEL_MEM  = 2'd1,
        SEL_WB   = 2'd2,
        SEL_RF   = 2'd3
    } opnd_sel_e;

    // Pipeline bank controls raised together on a load-use hazard.
    typedef struct packed {
        logic hold_fetch;
        logic hold_decode;
        logic flush_execute;
    } bank_ctrl_t;

    localparam bank_ctrl_t CTRL_RUN   = '{hold_fetch: 1'b0, hold_decode: 1'b0, flush_execute: 1'b0};
    localparam bank_ctrl_t CTRL_STALL = '{hold_fetch: 1'b1, hold_decode: 1'b1, flush_execute: 1'b1};

endpackage

// File: rtl/fhu_src_match.sv
module fhu_src_match #(
    parameter int unsigned       REG_W    = 4,
    parameter logic [REG_W-1:0]  NONE_REG = '1
) (
    input  logic [REG_W-1:0] src,
    input  logic [REG_W-1:0] dst,
    output logic             hit
);

    logic src_valid;

    always_comb begin
        src_valid = (src != NONE_REG);
        hit       = src_valid && (src == dst);
    end

endmodule

// File: rtl/fhu_opnd_path.sv
module fhu_opnd_path
    import fhu_pkg::*;
#(
    parameter int unsigned       REG_W    = 4,
    parameter int unsigned       DATA_W   = 64,
    parameter logic [REG_W-1:0]  NONE_REG = '1
) (
    input  logic [REG_W-1:0]  src,
    input  logic [REG_W-1:0]  mem_dst,
    input  logic [DATA_W-1:0] mem_data,
    input  logic [REG_W-1:0]  wb_dst,
    input  logic [DATA_W-1:0] wb_data,
    input  logic [DATA_W-1:0] rf_data,
    output logic [DATA_W-1:0] opnd
);

    logic      hit_mem;
    logic      hit_wb;
    opnd_sel_e sel;

    fhu_src_match #(.REG_W(REG_W), .NONE_REG(NONE_REG)) u_match_mem (
        .src (src),
        .dst (mem_dst),
        .hit (hit_mem)
    );

    fhu_src_match #(.REG_W(REG_W), .NONE_REG(NONE_REG)) u_match_wb (
        .src (src),
        .dst (wb_dst),
        .hit (hit_wb)
    );

    // Priority select: none code, then youngest producer, then register file.
    always_comb begin
        if (src == NONE_REG)  sel = SEL_ZERO;
        else if (hit_mem)     sel = SEL_MEM;
        else if (hit_wb)      sel = SEL_WB;
        else                  sel = SEL_RF;
    end

    always_comb begin
        unique case (sel)
            SEL_ZERO: opnd = '0;
            SEL_MEM:  opnd = mem_data;
            SEL_WB:   opnd = wb_data;
            SEL_RF:   opnd = rf_data;
            default:  opnd = '0;
        endcase
    end

endmodule

// File: rtl/fhu_loaduse.sv
module fhu_loaduse
    import fhu_pkg::*;
#(
    parameter int unsigned         REG_W     = 4,
    parameter int unsigned         ICODE_W   = 4,
    parameter logic [REG_W-1:0]    NONE_REG  = '1,
    parameter logic [ICODE_W-1:0]  LOAD_CODE = ICODE_W'(5)
) (
    input  logic [ICODE_W-1:0] ex_icode,
    input  logic [REG_W-1:0]   ex_dst,
    input  logic [REG_W-1:0]   src_a,
    input  logic [REG_W-1:0]   src_b,
    output bank_ctrl_t         ctrl
);

    logic hit_a;
    logic hit_b;
    logic ex_is_load;

    fhu_src_match #(.REG_W(REG_W), .NONE_REG(NONE_REG)) u_match_a (
        .src (src_a),
        .dst (ex_dst),
        .hit (hit_a)
    );

    fhu_src_match #(.REG_W(REG_W), .NONE_REG(NONE_REG)) u_match_b (
        .src (src_b),
        .dst (ex_dst),
        .hit (hit_b)
    );

    // Any matching source counts, used by the instruction or not.
    always_comb begin
        ex_is_load = (ex_icode == LOAD_CODE);
        ctrl       = (ex_is_load && (hit_a || hit_b)) ? CTRL_STALL : CTRL_RUN;
    end

endmodule

// File: rtl/fhu_fwd_hazard.sv
module fhu_fwd_hazard
    import fhu_pkg::*;
#(
    parameter int unsigned         REG_W     = 4,
    parameter int unsigned         DATA_W    = 64,
    parameter int unsigned         ICODE_W   = 4,
    parameter logic [REG_W-1:0]    NONE_REG  = '1,
    parameter logic [ICODE_W-1:0]  LOAD_CODE = ICODE_W'(5)
) (
    input  logic [REG_W-1:0]   dec_src_a,
    input  logic [REG_W-1:0]   dec_src_b,
    input  logic [ICODE_W-1:0] ex_icode,
    input  logic [REG_W-1:0]   ex_load_dst,
    input  logic [REG_W-1:0]   mem_load_dst,
    input  logic [DATA_W-1:0]  mem_load_data,
    input  logic [REG_W-1:0]   wb_load_dst,
    input  logic [DATA_W-1:0]  wb_load_data,
    input  logic [DATA_W-1:0]  rf_rd_a,
    input  logic [DATA_W-1:0]  rf_rd_b,
    output logic [DATA_W-1:0]  opnd_a,
    output logic [DATA_W-1:0]  opnd_b,
    output logic               hold_fetch,
    output logic               hold_decode,
    output logic               flush_execute
);

    localparam int unsigned N_PORTS = 2;

    logic [REG_W-1:0]  src_v  [N_PORTS];
    logic [DATA_W-1:0] rf_v   [N_PORTS];
    logic [DATA_W-1:0] opnd_v [N_PORTS];
    bank_ctrl_t        ctrl;

    always_comb begin
        src_v[0] = dec_src_a;
        src_v[1] = dec_src_b;
        rf_v[0]  = rf_rd_a;
        rf_v[1]  = rf_rd_b;
    end

    for (genvar p = 0; p < N_PORTS; p++) begin : g_port
        fhu_opnd_path #(
            .REG_W    (REG_W),
            .DATA_W   (DATA_W),
            .NONE_REG (NONE_REG)
        ) u_path (
            .src      (src_v[p]),
            .mem_dst  (mem_load_dst),
            .mem_data (mem_load_data),
            .wb_dst   (wb_load_dst),
            .wb_data  (wb_load_data),
            .rf_data  (rf_v[p]),
            .opnd     (opnd_v[p])
        );
    end

    fhu_loaduse #(
        .REG_W     (REG_W),
        .ICODE_W   (ICODE_W),
        .NONE_REG  (NONE_REG),
        .LOAD_CODE (LOAD_CODE)
    ) u_loaduse (
        .ex_icode (ex_icode),
        .ex_dst   (ex_load_dst),
        .src_a    (dec_src_a),
        .src_b    (dec_src_b),
        .ctrl     (ctrl)
    );

    always_comb begin
        opnd_a        = opnd_v[0];
        opnd_b        = opnd_v[1];
        hold_fetch    = ctrl.hold_fetch;
        hold_decode   = ctrl.hold_decode;
        flush_execute = ctrl.flush_execute;
    end

endmodule

// File: rtl/fhu_checker.sv
module fhu_checker #(
    parameter int unsigned         REG_W     = 4,
    parameter int unsigned         DATA_W    = 64,
    parameter int unsigned         ICODE_W   = 4,
    parameter logic [REG_W-1:0]    NONE_REG  = '1,
    parameter logic [ICODE_W-1:0]  LOAD_CODE = ICODE_W'(5)
) (
    input logic [REG_W-1:0]   dec_src_a,
    input logic [REG_W-1:0]   dec_src_b,
    input logic [ICODE_W-1:0] ex_icode,
    input logic [REG_W-1:0]   ex_load_dst,
    input logic [REG_W-1:0]   mem_load_dst,
    input logic [DATA_W-1:0]  mem_load_data,
    input logic [REG_W-1:0]   wb_load_dst,
    input logic [DATA_W-1:0]  wb_load_data,
    input logic [DATA_W-1:0]  rf_rd_a,
    input logic [DATA_W-1:0]  rf_rd_b,
    input logic [DATA_W-1:0]  opnd_a,
    input logic [DATA_W-1:0]  opnd_b,
    input logic               hold_fetch,
    input logic               hold_decode,
    input logic               flush_execute
);

    always_comb begin
        if (dec_src_a == NONE_REG)
            AST_NONE_GIVES_ZERO: assert (opnd_a == '0); // R1
        if (dec_src_a != NONE_REG && dec_src_a == mem_load_dst)
            AST_MEM_FORWARD_A: assert (opnd_a == mem_load_data); // R2
        if (dec_src_a != NONE_REG && dec_src_a != mem_load_dst && dec_src_a == wb_load_dst)
            AST_WB_FORWARD_A: assert (opnd_a == wb_load_data); // R3
        if (dec_src_b != NONE_REG && dec_src_b == mem_load_dst)
            AST_MEM_OVER_WB_B: assert (opnd_b == mem_load_data); // R4
        if (dec_src_a != NONE_REG && dec_src_a != mem_load_dst && dec_src_a != wb_load_dst)
            AST_RF_PASS_A: assert (opnd_a == rf_rd_a); // R5
        if (dec_src_b != NONE_REG && dec_src_b != mem_load_dst && dec_src_b != wb_load_dst)
            AST_RF_PASS_B: assert (opnd_b == rf_rd_b); // R6
        if (hold_fetch)
            AST_HOLD_NEEDS_MATCH: assert (ex_load_dst == dec_src_a || ex_load_dst == dec_src_b); // R8
        if (ex_icode == LOAD_CODE && ex_load_dst == dec_src_a && dec_src_a != NONE_REG)
            AST_LOADUSE_A: assert (hold_fetch); // R7
        if (ex_icode != LOAD_CODE)
            AST_NO_LOAD_NO_HOLD: assert (!hold_fetch); // R9
        AST_CTRL_TIED: assert (hold_fetch == hold_decode && hold_decode == flush_execute); // R10
    end

endmodule

bind fhu_fwd_hazard fhu_checker #(
    .REG_W     (REG_W),
    .DATA_W    (DATA_W),
    .ICODE_W   (ICODE_W),
    .NONE_REG  (NONE_REG),
    .LOAD_CODE (LOAD_CODE)
) u_fhu_checker (
    .dec_src_a     (dec_src_a),
    .dec_src_b     (dec_src_b),
    .ex_icode      (ex_icode),
    .ex_load_dst   (ex_load_dst),
    .mem_load_dst  (mem_load_dst),
    .mem_load_data (mem_load_data),
    .wb_load_dst   (wb_load_dst),
    .wb_load_data  (wb_load_data),
    .rf_rd_a       (rf_rd_a),
    .rf_rd_b       (rf_rd_b),
    .opnd_a        (opnd_a),
    .opnd_b        (opnd_b),
    .hold_fetch    (hold_fetch),
    .hold_decode   (hold_decode),
    .flush_execute (flush_execute)
);

// File: tb/test_fhu_fwd_hazard.sv
module test_fhu_fwd_hazard;

    localparam logic [63:0] DM  = 64'h0000_AAAA_0000_0001;
    localparam logic [63:0] DW  = 64'h0000_BBBB_0000_0002;
    localparam logic [63:0] DRA = 64'h0000_CCCC_0000_0003;
    localparam logic [63:0] DRB = 64'h0000_DDDD_0000_0004;

    typedef struct packed {
        logic [3:0]  src_a;
        logic [3:0]  src_b;
        logic [3:0]  icode;
        logic [3:0]  ex_dst;
        logic [3:0]  mem_dst;
        logic [3:0]  wb_dst;
        logic [63:0] exp_a;
        logic [63:0] exp_b;
        logic        exp_hz;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VECS [NV] = '{
        '{4'hF, 4'hF, 4'h1, 4'hF, 4'hF, 4'hF, 64'd0, 64'd0, 1'b0}, // R1 all none
        '{4'h1, 4'h2, 4'h1, 4'hF, 4'hF, 4'hF, DRA,   DRB,   1'b0}, // R5
        '{4'h3, 4'h2, 4'h1, 4'hF, 4'h3, 4'hF, DM,    DRB,   1'b0}, // R2
        '{4'h1, 4'h6, 4'h1, 4'hF, 4'hF, 4'h6, DRA,   DW,    1'b0}, // R3
        '{4'h7, 4'h7, 4'h1, 4'hF, 4'h7, 4'h7, DM,    DM,    1'b0}, // R4
        '{4'h2, 4'h9, 4'h1, 4'hF, 4'h2, 4'h9, DM,    DW,    1'b0}, // R6
        '{4'h1, 4'hF, 4'h5, 4'h1, 4'hF, 4'hF, DRA,   64'd0, 1'b1}, // R7
        '{4'hF, 4'h4, 4'h5, 4'h4, 4'hF, 4'hF, 64'd0, DRB,   1'b1}, // R8
        '{4'h8, 4'h4, 4'h4, 4'h4, 4'hF, 4'hF, DRA,   DRB,   1'b0}, // R9
        '{4'hF, 4'h3, 4'h5, 4'hF, 4'hF, 4'hF, 64'd0, DRB,   1'b0}, // R1 none never matches
        '{4'h2, 4'h5, 4'h5, 4'h2, 4'h2, 4'h2, DM,    DRB,   1'b1}  // R11
    };

    logic        clk = 1'b0;
    logic [3:0]  dec_src_a, dec_src_b, ex_icode, ex_load_dst, mem_load_dst, wb_load_dst;
    logic [63:0] mem_load_data, wb_load_data, rf_rd_a, rf_rd_b, opnd_a, opnd_b;
    logic        hold_fetch, hold_decode, flush_execute;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #5 clk = ~clk;

    fhu_fwd_hazard i_fhu_fwd_hazard (
        .dec_src_a     (dec_src_a),
        .dec_src_b     (dec_src_b),
        .ex_icode      (ex_icode),
        .ex_load_dst   (ex_load_dst),
        .mem_load_dst  (mem_load_dst),
        .mem_load_data (mem_load_data),
        .wb_load_dst   (wb_load_dst),
        .wb_load_data  (wb_load_data),
        .rf_rd_a       (rf_rd_a),
        .rf_rd_b       (rf_rd_b),
        .opnd_a        (opnd_a),
        .opnd_b        (opnd_b),
        .hold_fetch    (hold_fetch),
        .hold_decode   (hold_decode),
        .flush_execute (flush_execute)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic drive(input vec_t v);
        @(negedge clk);
        dec_src_a    = v.src_a;
        dec_src_b    = v.src_b;
        ex_icode     = v.icode;
        ex_load_dst  = v.ex_dst;
        mem_load_dst = v.mem_dst;
        wb_load_dst  = v.wb_dst;
        #2;
    endtask

    task automatic check_ctrl(input string req, input logic exp);
        check(req, {61'd0, hold_fetch, hold_decode, flush_execute}, {61'd0, exp, exp, exp});
    endtask

    initial begin
        mem_load_data = DM;
        wb_load_data  = DW;
        rf_rd_a       = DRA;
        rf_rd_b       = DRB;
        // Idle state: all sources none, no load anywhere (R1, R10)
        drive('{4'hF, 4'hF, 4'h0, 4'hF, 4'hF, 4'hF, 64'd0, 64'd0, 1'b0});
        check("R1 idle opnd_a", opnd_a, 64'd0);
        check("R10 idle ctrl", {61'd0, hold_fetch, hold_decode, flush_execute}, 64'd0);

        for (int i = 0; i < NV; i++) begin
            drive(VECS[i]);
            check($sformatf("vec%0d opnd_a", i), opnd_a, VECS[i].exp_a);
            check($sformatf("vec%0d opnd_b", i), opnd_b, VECS[i].exp_b);
            check_ctrl($sformatf("vec%0d R10 ctrl", i), VECS[i].exp_hz);
        end

        // R7 sweep: load to register 3 in execute, every source A code
        for (int s = 0; s < 16; s++) begin
            drive('{4'(s), 4'hF, 4'h5, 4'h3, 4'hF, 4'hF, 64'd0, 64'd0, 1'b0});
            check($sformatf("R7 sweep src %0d ctrl", s),
                  {63'd0, hold_fetch}, {63'd0, (s == 3)});
            check($sformatf("R1 sweep src %0d opnd", s),
                  opnd_a, (s == 15) ? 64'd0 : DRA);
        end

        // R11: hazard via B while A forwards from writeback
        drive('{4'h6, 4'hA, 4'h5, 4'hA, 4'hF, 4'h6, 64'd0, 64'd0, 1'b0});
        check("R11 opnd_a wb during hazard", opnd_a, DW);
        check_ctrl("R8 ctrl via B", 1'b1);

        // R2: data change on memory stage propagates with the select
        drive('{4'h2, 4'hF, 4'h1, 4'hF, 4'h2, 4'hF, 64'd0, 64'd0, 1'b0});
        mem_load_data = 64'h1234_5678_9ABC_DEF0;
        #1;
        check("R2 new mem data", opnd_a, 64'h1234_5678_9ABC_DEF0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

endmodule